// File: doc/BRIEF.md
# Two-Stage Stream Register File Port Arbiter

This block decides, once per clock, which client owns the single port of a banked stream register file. Two kinds of client compete. Sequential streams each want one wide block transfer that spans every lane. Indexed streams issue single-word accesses that each lane serves on its own. The global stage runs one round-robin rotation. Each sequential stream holds one slot in it, and the indexed class as a whole holds one more slot. The indexed class takes part in the rotation whenever any lane has any indexed access waiting.

Each lane runs its own local selection in the same cycle as the global stage. It does not wait for the global result. It looks at the head access of each of its indexed streams and picks a set that has no subarray conflict. A lower-numbered stream has priority within the lane. If the indexed class wins the global stage, these picks are registered as commit strobes, and the owning FIFO heads may advance on them. If a sequential stream wins, every pick is discarded.

A sequential stream drives its request only when its buffer can take a whole block (for a read) or holds a whole block (for a write). The arbiter does not check this. It takes the request line as already qualified. Bank timing and data movement belong to the neighbouring blocks.

Top module: `two_stage_port_arb`

## Requirements
- R1: When reset is asserted, `seq_gnt`, `idx_en` and `idx_commit` are zero on the next cycle. After reset, the rotation pointer points at sequential stream 0.
- R2: `seq_gnt` has at most one bit set. `idx_en` is never high while any `seq_gnt` bit is high.
- R3: The indexed class takes rotation slot NUM_SEQ, which follows the last sequential stream. It requests in any cycle where at least one bit of `idx_vld` is set. `idx_en` is the grant for this slot.
- R4: Rotation slots are numbered 0..NUM_SEQ. The winner is the first requesting slot, scanning upward from the pointer and wrapping around. After a grant, the pointer moves to the slot just past the winner.
- R5: In a cycle with no request of either kind, no grant is issued and the pointer keeps its value.
- R6: Every output is registered. A decision made from the inputs present before a rising edge appears just after that edge and holds for one cycle.
- R7: Streams are flattened as k = lane*NUM_IDX + s, and `idx_sub` field k sits at bits [k*SUB_W +: SUB_W]. Within a lane, a valid access s is picked unless a lower-numbered stream of the same lane was picked for the same subarray. An invalid stream blocks nothing.
- R8: `idx_commit` can be nonzero only in a cycle where `idx_en` is high. When a sequential stream wins, all local picks are dropped.
- R9: Each lane selects independently. The same subarray number used in different lanes causes no conflict.
- R10: A grant bit is high only if the matching request was present in the decision cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seq_req | input | NUM_SEQ | Per sequential stream: buffer ready for one full block |
| idx_vld | input | NUM_LANES*NUM_IDX | Head of each lane's indexed address FIFO is valid |
| idx_sub | input | NUM_LANES*NUM_IDX*SUB_W | Subarray targeted by each head access |
| seq_gnt | output | NUM_SEQ | One-hot registered sequential grant |
| idx_en | output | 1 | Registered grant to the whole indexed class |
| idx_commit | output | NUM_LANES*NUM_IDX | Registered per-stream commit, advances FIFO heads |

## Verification
The bench builds the block with three sequential streams, two lanes, three indexed streams per lane and two subarrays. With these values a four-slot rotation wraps within a few cycles. Two subarrays make subarray conflicts between streams of the same lane easy to provoke. Two lanes allow the same subarray number to appear in both lanes at once, so lane independence can be checked. Hand-computed vectors follow the pointer through wraps, idle cycles, discarded speculative picks and the case where a lower-numbered stream is idle. Directed steps cover reset, both during a run and after one, and the one-cycle output latency.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Which client class won the global stage in a cycle.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SEQ  = 2'd1,
        WIN_IDX  = 2'd2
    } win_kind_e;

    // Bits needed to name one subarray; never less than one.
    function automatic int sub_bits(input int n_sub);
        return (n_sub > 1) ? $clog2(n_sub) : 1;
    endfunction

    // Bits needed for a rotation pointer over n slots.
    function automatic int ptr_bits(input int n_slots);
        return (n_slots > 1) ? $clog2(n_slots) : 1;
    endfunction

    // Slot that follows pos in a ring of n slots.
    function automatic int next_slot(input int pos, input int n);
        return (pos + 1 >= n) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/port_rr_select.sv
module port_rr_select
    import arb_pkg::*;
#(
    parameter int N_SLOTS = 5,
    localparam int PW = ptr_bits(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] req,
    input  logic [PW-1:0]      ptr,
    output logic               win_valid,
    output logic [PW-1:0]      win_slot,
    output logic [N_SLOTS-1:0] win_onehot
);

    always_comb begin
        win_valid  = 1'b0;
        win_slot   = '0;
        win_onehot = '0;
        for (int k = 0; k < N_SLOTS; k++) begin
            int pos;
            pos = int'(ptr) + k;
            if (pos >= N_SLOTS) pos = pos - N_SLOTS;
            if (!win_valid && req[pos]) begin
                win_valid       = 1'b1;
                win_slot        = PW'(pos);
                win_onehot[pos] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lane_local_pick.sv
module lane_local_pick
    import arb_pkg::*;
#(
    parameter int NUM_IDX = 2,
    parameter int NUM_SUB = 4,
    localparam int SUB_W  = sub_bits(NUM_SUB)
) (
    input  logic [NUM_IDX-1:0]       vld,
    input  logic [NUM_IDX*SUB_W-1:0] sub,
    output logic [NUM_IDX-1:0]       pick
);

    logic [(1<<SUB_W)-1:0] busy;

    // Lower stream number claims its subarray first.
    always_comb begin
        busy = '0;
        pick = '0;
        for (int s = 0; s < NUM_IDX; s++) begin
            logic [SUB_W-1:0] tgt;
            tgt = sub[s*SUB_W +: SUB_W];
            if (vld[s] && !busy[tgt]) begin
                pick[s]   = 1'b1;
                busy[tgt] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/two_stage_port_arb.sv
module two_stage_port_arb
    import arb_pkg::*;
#(
    parameter int NUM_SEQ   = 4,
    parameter int NUM_LANES = 8,
    parameter int NUM_IDX   = 2,
    parameter int NUM_SUB   = 4
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic [NUM_SEQ-1:0]                            seq_req,
    input  logic [NUM_LANES*NUM_IDX-1:0]                  idx_vld,
    input  logic [NUM_LANES*NUM_IDX*sub_bits(NUM_SUB)-1:0] idx_sub,
    output logic [NUM_SEQ-1:0]                            seq_gnt,
    output logic                                          idx_en,
    output logic [NUM_LANES*NUM_IDX-1:0]                  idx_commit
);

    localparam int SUB_W   = sub_bits(NUM_SUB);
    localparam int N_SLOTS = NUM_SEQ + 1;
    localparam int PW      = ptr_bits(N_SLOTS);
    localparam int N_STRM  = NUM_LANES * NUM_IDX;

    // Stage two: speculative local picks, one selector per lane.
    logic [N_STRM-1:0] spec_pick;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        lane_local_pick #(
            .NUM_IDX (NUM_IDX),
            .NUM_SUB (NUM_SUB)
        ) i_pick (
            .vld  (idx_vld[ln*NUM_IDX +: NUM_IDX]),
            .sub  (idx_sub[ln*NUM_IDX*SUB_W +: NUM_IDX*SUB_W]),
            .pick (spec_pick[ln*NUM_IDX +: NUM_IDX])
        );
    end

    // Stage one: global rotation, indexed class in the last slot.
    logic [N_SLOTS-1:0] slot_req;
    logic [PW-1:0]      ptr_q;
    logic               win_valid;
    logic [PW-1:0]      win_slot;
    logic [N_SLOTS-1:0] win_onehot;

    assign slot_req = {|idx_vld, seq_req};

    port_rr_select #(
        .N_SLOTS (N_SLOTS)
    ) i_global (
        .req        (slot_req),
        .ptr        (ptr_q),
        .win_valid  (win_valid),
        .win_slot   (win_slot),
        .win_onehot (win_onehot)
    );

    win_kind_e win_kind;

    always_comb begin
        if (!win_valid)              win_kind = WIN_NONE;
        else if (win_onehot[NUM_SEQ]) win_kind = WIN_IDX;
        else                          win_kind = WIN_SEQ;
    end

    // Registered decision.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            seq_gnt    <= '0;
            idx_en     <= 1'b0;
            idx_commit <= '0;
        end else begin
            seq_gnt    <= (win_kind == WIN_SEQ) ? win_onehot[NUM_SEQ-1:0] : '0;
            idx_en     <= (win_kind == WIN_IDX);
            idx_commit <= (win_kind == WIN_IDX) ? spec_pick : '0;
            if (win_valid)
                ptr_q <= PW'(next_slot(int'(win_slot), N_SLOTS));
        end
    end

endmodule

// File: rtl/two_stage_port_arb_chk.sv
module two_stage_port_arb_chk
    import arb_pkg::*;
#(
    parameter int NUM_SEQ   = 4,
    parameter int NUM_LANES = 8,
    parameter int NUM_IDX   = 2,
    parameter int NUM_SUB   = 4
) (
    input logic                                          clk,
    input logic                                          rst,
    input logic [NUM_SEQ-1:0]                            seq_req,
    input logic [NUM_LANES*NUM_IDX-1:0]                  idx_vld,
    input logic [NUM_LANES*NUM_IDX*sub_bits(NUM_SUB)-1:0] idx_sub,
    input logic [NUM_SEQ-1:0]                            seq_gnt,
    input logic                                          idx_en,
    input logic [NUM_LANES*NUM_IDX-1:0]                  idx_commit
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seq_gnt, idx_en}))
        else $error("R2 grant not exclusive");

    p_commit_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        (|idx_commit) |-> idx_en)
        else $error("R8 commit without indexed grant");

    p_idx_had_pending_r3: assert property (@(posedge clk) disable iff (rst)
        idx_en |-> $past(|idx_vld))
        else $error("R3 indexed grant without pending access");

    p_idle_no_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (!(|seq_req) && !(|idx_vld)) |=> !(|seq_gnt) && !idx_en)
        else $error("R5 grant after idle cycle");

    for (genvar i = 0; i < NUM_SEQ; i++) begin : g_seq
        p_gnt_had_req_r10: assert property (@(posedge clk) disable iff (rst)
            seq_gnt[i] |-> $past(seq_req[i]))
            else $error("R10 grant without request");
    end

    for (genvar k = 0; k < NUM_LANES*NUM_IDX; k++) begin : g_strm
        p_commit_had_vld_r7: assert property (@(posedge clk) disable iff (rst)
            idx_commit[k] |-> $past(idx_vld[k]))
            else $error("R7 commit for invalid stream");
    end

endmodule

bind two_stage_port_arb two_stage_port_arb_chk #(
    .NUM_SEQ   (NUM_SEQ),
    .NUM_LANES (NUM_LANES),
    .NUM_IDX   (NUM_IDX),
    .NUM_SUB   (NUM_SUB)
) i_chk (.*);

// File: tb/test_two_stage_port_arb.sv
module test_two_stage_port_arb;

    localparam int CLK_PERIOD = 10;
    localparam int NSEQ  = 3;
    localparam int NLANE = 2;
    localparam int NIDX  = 3;
    localparam int NSUB  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] seq_req = '0;
    logic [5:0] idx_vld = '0;
    logic [5:0] idx_sub = '0;
    logic [2:0] seq_gnt;
    logic       idx_en;
    logic [5:0] idx_commit;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    two_stage_port_arb #(
        .NUM_SEQ   (NSEQ),
        .NUM_LANES (NLANE),
        .NUM_IDX   (NIDX),
        .NUM_SUB   (NSUB)
    ) i_two_stage_port_arb (
        .clk        (clk),
        .rst        (rst),
        .seq_req    (seq_req),
        .idx_vld    (idx_vld),
        .idx_sub    (idx_sub),
        .seq_gnt    (seq_gnt),
        .idx_en     (idx_en),
        .idx_commit (idx_commit)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic [2:0] req;
        logic [5:0] vld;
        logic [5:0] sub;
        logic [2:0] gnt;
        logic       en;
        logic [5:0] com;
    } vec_t;

    // Walked in order from reset; the pointer carries across rows.
    localparam vec_t VECS [13] = '{
        '{4'd5, 3'b000, 6'b000000, 6'b000000, 3'b000, 1'b0, 6'b000000}, // R5 idle, ptr 0
        '{4'd1, 3'b111, 6'b000000, 6'b000000, 3'b001, 1'b0, 6'b000000}, // R1 ptr 0 -> seq0
        '{4'd4, 3'b111, 6'b000000, 6'b000000, 3'b010, 1'b0, 6'b000000}, // R4 seq1
        '{4'd8, 3'b111, 6'b000001, 6'b000000, 3'b100, 1'b0, 6'b000000}, // R8 seq2 wins, pick dropped
        '{4'd3, 3'b111, 6'b000001, 6'b000000, 3'b000, 1'b1, 6'b000001}, // R3 indexed slot
        '{4'd7, 3'b000, 6'b111111, 6'b011100, 3'b000, 1'b1, 6'b101101}, // R7 conflicts in both lanes
        '{4'd5, 3'b000, 6'b000000, 6'b000000, 3'b000, 1'b0, 6'b000000}, // R5 idle keeps ptr 0
        '{4'd4, 3'b100, 6'b000000, 6'b000000, 3'b100, 1'b0, 6'b000000}, // R4 seq2, ptr -> 3
        '{4'd4, 3'b011, 6'b000000, 6'b000000, 3'b001, 1'b0, 6'b000000}, // R4 wrap 3 -> seq0
        '{4'd9, 3'b001, 6'b010000, 6'b000000, 3'b000, 1'b1, 6'b010000}, // R9 only lane1 pending
        '{4'd8, 3'b001, 6'b010000, 6'b000000, 3'b001, 1'b0, 6'b000000}, // R8 seq0 after wrap
        '{4'd9, 3'b000, 6'b001001, 6'b000000, 3'b000, 1'b1, 6'b001001}, // R9 same sub, two lanes
        '{4'd7, 3'b000, 6'b000110, 6'b000110, 3'b000, 1'b1, 6'b000010}  // R7 idle s0 blocks nothing
    };

    task automatic check(input string tag, input logic [2:0] g,
                         input logic e, input logic [5:0] c);
        n_cmp++;
        if (seq_gnt !== g || idx_en !== e || idx_commit !== c) begin
            n_bad++;
            $display("FAIL %s: gnt=%b en=%b commit=%b expected gnt=%b en=%b commit=%b",
                     tag, seq_gnt, idx_en, idx_commit, g, e, c);
        end
    endtask

    task automatic drive(input logic [2:0] r, input logic [5:0] v, input logic [5:0] s);
        seq_req = r;
        idx_vld = v;
        idx_sub = s;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state with requests already present.
        drive(3'b111, 6'b111111, 6'b000000);
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset outputs", 3'b000, 1'b0, 6'b000000);
        drive(3'b000, 6'b000000, 6'b000000);
        rst = 1'b0;

        for (int i = 0; i < 13; i++) begin
            drive(VECS[i].req, VECS[i].vld, VECS[i].sub);
            @(posedge clk);
            #1;
            check($sformatf("R%0d row %0d", VECS[i].rq, i),
                  VECS[i].gnt, VECS[i].en, VECS[i].com);
        end

        // R6: a new request is not visible before the next edge.
        drive(3'b000, 6'b000000, 6'b000000);
        @(posedge clk);
        #1;
        drive(3'b010, 6'b000000, 6'b000000);
        #2;
        check("R6 before edge", 3'b000, 1'b0, 6'b000000);
        @(posedge clk);
        #1;
        check("R6 after edge", 3'b010, 1'b0, 6'b000000);

        // R1: mid-run reset returns the pointer to slot 0 (ptr was 2).
        drive(3'b111, 6'b000000, 6'b000000);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 3'b000, 1'b0, 6'b000000);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 pointer at slot 0", 3'b001, 1'b0, 6'b000000);

        // R2: all slots requesting for a full turn gives one grant per cycle.
        drive(3'b111, 6'b000001, 6'b000000);
        @(posedge clk);
        #1;
        check("R2 turn slot1", 3'b010, 1'b0, 6'b000000);
        @(posedge clk);
        #1;
        check("R2 turn slot2", 3'b100, 1'b0, 6'b000000);
        @(posedge clk);
        #1;
        check("R2 turn slot3", 3'b000, 1'b1, 6'b000001);
        @(posedge clk);
        #1;
        check("R2 turn slot0", 3'b001, 1'b0, 6'b000000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule